// File: doc/BRIEF.md
# Processor Status and Exception Save Register File

This block keeps the processor's live status bits (stack select, interrupt enable, condition flag) and their saved copies, two stack pointers, and the program counter saved at exception entry. The core reaches these registers through a numbered control-register port with a combinational read and a write that lands on the next clock edge. A separate register-15 port reads or writes whichever stack pointer the stack-select bit currently chooses.

An exception-entry strobe saves the live status bits into their saved fields and captures the faulting program counter. A return strobe puts the saved status bits back into the live bits and offers a word-aligned return address. A condition-flag port lets the ALU update the condition bit directly.

Register numbers are 0 for the status word, 1 for the condition view, 2 for the interrupt-side stack pointer, 3 for the user-side stack pointer and 6 for the saved program counter. Reset is asynchronous and active low. Its release is synchronised inside the block, so state stays cleared for two clock edges after `rst_n` rises.

Top module: `status_exc_regfile`

## Requirements
- R1: While reset is asserted, every register reads zero: the status word, both stack pointers, the saved program counter and the return address. The saved status fields are cleared along with the live ones.
- R2: The status word (number 0) holds live condition at bit 0, live interrupt enable at bit 6, live stack select at bit 7, saved condition at bit 8, saved interrupt enable at bit 14 and saved stack select at bit 15. Writes set exactly these six bits, and every other bit reads 0.
- R3: Number 1 always reads the live condition bit at bit 0, with all other bits 0. Writes to number 1 change nothing.
- R4: The register-15 port reads and writes the interrupt-side stack pointer (number 2) when stack select is 0, and the user-side stack pointer (number 3) when stack select is 1.
- R5: On an exception-entry strobe, the live stack select, interrupt enable and condition are copied into their saved fields on the next edge. The live bits keep their values.
- R6: The saved program counter (number 6) loads the exception PC on entry, or the write data on a control write. In both cases bit 0 is stored as 0.
- R7: `ret_pc` always equals the saved program counter with its two low bits forced to 00. A return strobe copies the saved status fields back into the live bits.
- R8: When an exception entry coincides with a control-register write, the write is discarded. Entry also takes precedence over a coincident return strobe.
- R9: A condition-flag update sets the live condition bit on the next edge, unless an entry, a return or a status-word write occurs in the same cycle. Each of those takes precedence.
- R10: Control-register numbers 4, 5 and 7 read zero and ignore writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cr_wr_en | input | 1 | Control-register write strobe |
| cr_addr | input | 3 | Control-register number |
| cr_wdata | input | 32 | Control-register write data |
| cr_rdata | output | 32 | Control-register read data (combinational) |
| gpr15_wr_en | input | 1 | Register-15 write strobe |
| gpr15_wdata | input | 32 | Register-15 write data |
| gpr15_rdata | output | 32 | Active stack pointer |
| cflag_wr_en | input | 1 | Condition-flag update strobe |
| cflag_wdata | input | 1 | New condition-flag value |
| exc_entry | input | 1 | Exception-entry strobe |
| exc_pc | input | 32 | Program counter to save on entry |
| exc_return | input | 1 | Return-from-exception strobe |
| ret_pc | output | 32 | Word-aligned return address |
| stack_sel | output | 1 | Live stack-select bit |
| int_en | output | 1 | Live interrupt-enable bit |
| cond_flag | output | 1 | Live condition bit |

## Verification
The properties assume that strobes and write data are stable around the rising edge. They also assume that register-15 writes never share a cycle with a control write that targets the same stack pointer, since that case would make the selected-pointer check ambiguous. The bench drives every input on the falling edge and issues one register-15 or control write per cycle, except in the deliberate collision cases. Those collisions cover entry against control write and flag update against status write, and they are checked at the ports one cycle later.

// File: rtl/exc_regs_pkg.sv
package exc_regs_pkg;
  localparam int unsigned CR_AW = 3;

  localparam logic [CR_AW-1:0] CRN_STATUS = 3'd0;
  localparam logic [CR_AW-1:0] CRN_CONDV  = 3'd1;
  localparam logic [CR_AW-1:0] CRN_ISTACK = 3'd2;
  localparam logic [CR_AW-1:0] CRN_USTACK = 3'd3;
  localparam logic [CR_AW-1:0] CRN_SAVEPC = 3'd6;

  localparam int unsigned BIT_C   = 0;
  localparam int unsigned BIT_IE  = 6;
  localparam int unsigned BIT_SM  = 7;
  localparam int unsigned BIT_BC  = 8;
  localparam int unsigned BIT_BIE = 14;
  localparam int unsigned BIT_BSM = 15;

  localparam int unsigned NUM_SP = 2;
  localparam int unsigned SP_INT = 0;
  localparam int unsigned SP_USR = 1;

  typedef struct packed {
    logic sm;
    logic ie;
    logic c;
  } mode_bits_t;
endpackage

// File: rtl/status_word_unit.sv
module status_word_unit
  import exc_regs_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       entry,
  input  logic       ret,
  input  logic       sw_we,
  input  mode_bits_t sw_live_d,
  input  mode_bits_t sw_bkup_d,
  input  logic       cf_we,
  input  logic       cf_d,
  output mode_bits_t live_q,
  output mode_bits_t bkup_q
);
  mode_bits_t live_n, bkup_n;
  logic       live_en, bkup_en;

  always_comb begin
    live_n  = live_q;
    bkup_n  = bkup_q;
    live_en = 1'b0;
    bkup_en = 1'b0;
    if (entry) begin
      bkup_n  = live_q;
      bkup_en = 1'b1;
    end else if (ret) begin
      live_n  = bkup_q;
      live_en = 1'b1;
    end else if (sw_we) begin
      live_n  = sw_live_d;
      bkup_n  = sw_bkup_d;
      live_en = 1'b1;
      bkup_en = 1'b1;
    end else if (cf_we) begin
      live_n.c = cf_d;
      live_en  = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      live_q <= '0;
    end else if (live_en) begin
      live_q <= live_n;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bkup_q <= '0;
    end else if (bkup_en) begin
      bkup_q <= bkup_n;
    end
  end
endmodule

// File: rtl/stack_ptr_bank.sv
module stack_ptr_bank
  import exc_regs_pkg::*;
#(
  parameter int unsigned W = 32
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic [NUM_SP-1:0]        we,
  input  logic [NUM_SP-1:0][W-1:0] wd,
  output logic [NUM_SP-1:0][W-1:0] q
);
  for (genvar i = 0; i < NUM_SP; i++) begin : g_sp
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        q[i] <= '0;
      end else if (we[i]) begin
        q[i] <= wd[i];
      end
    end
  end
endmodule

// File: rtl/save_pc_reg.sv
module save_pc_reg #(
  parameter int unsigned W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         entry,
  input  logic [W-1:0] entry_pc,
  input  logic         wr,
  input  logic [W-1:0] wr_data,
  output logic [W-1:0] save_q,
  output logic [W-1:0] ret_addr
);
  logic [W-1:0] save_n;
  logic         save_en;

  always_comb begin
    save_en = entry | wr;
    save_n  = entry ? entry_pc : wr_data;
    save_n[0] = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      save_q <= '0;
    end else if (save_en) begin
      save_q <= save_n;
    end
  end

  assign ret_addr = {save_q[W-1:2], 2'b00};
endmodule

// File: rtl/status_exc_regfile.sv
module status_exc_regfile
  import exc_regs_pkg::*;
#(
  parameter int unsigned W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cr_wr_en,
  input  logic [CR_AW-1:0] cr_addr,
  input  logic [W-1:0]     cr_wdata,
  output logic [W-1:0]     cr_rdata,
  input  logic             gpr15_wr_en,
  input  logic [W-1:0]     gpr15_wdata,
  output logic [W-1:0]     gpr15_rdata,
  input  logic             cflag_wr_en,
  input  logic             cflag_wdata,
  input  logic             exc_entry,
  input  logic [W-1:0]     exc_pc,
  input  logic             exc_return,
  output logic [W-1:0]     ret_pc,
  output logic             stack_sel,
  output logic             int_en,
  output logic             cond_flag
);
  logic       rst_s1, rst_sync_n;
  mode_bits_t live, bkup, sw_live_d, sw_bkup_d;
  logic       cr_we_eff, sw_we;
  logic [NUM_SP-1:0]        sp_we;
  logic [NUM_SP-1:0][W-1:0] sp_wd, sp_q;
  logic [W-1:0] save_pc;
  logic [W-1:0] status_img;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_s1     <= 1'b0;
      rst_sync_n <= 1'b0;
    end else begin
      rst_s1     <= 1'b1;
      rst_sync_n <= rst_s1;
    end
  end

  always_comb begin
    cr_we_eff    = cr_wr_en & ~exc_entry;
    sw_we        = cr_we_eff && (cr_addr == CRN_STATUS);
    sw_live_d.sm = cr_wdata[BIT_SM];
    sw_live_d.ie = cr_wdata[BIT_IE];
    sw_live_d.c  = cr_wdata[BIT_C];
    sw_bkup_d.sm = cr_wdata[BIT_BSM];
    sw_bkup_d.ie = cr_wdata[BIT_BIE];
    sw_bkup_d.c  = cr_wdata[BIT_BC];
  end

  always_comb begin
    sp_we[SP_INT] = (cr_we_eff && (cr_addr == CRN_ISTACK)) | (gpr15_wr_en & ~live.sm);
    sp_we[SP_USR] = (cr_we_eff && (cr_addr == CRN_USTACK)) | (gpr15_wr_en &  live.sm);
    sp_wd[SP_INT] = (cr_we_eff && (cr_addr == CRN_ISTACK)) ? cr_wdata : gpr15_wdata;
    sp_wd[SP_USR] = (cr_we_eff && (cr_addr == CRN_USTACK)) ? cr_wdata : gpr15_wdata;
  end

  status_word_unit u_sw (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .entry     (exc_entry),
    .ret       (exc_return),
    .sw_we     (sw_we),
    .sw_live_d (sw_live_d),
    .sw_bkup_d (sw_bkup_d),
    .cf_we     (cflag_wr_en),
    .cf_d      (cflag_wdata),
    .live_q    (live),
    .bkup_q    (bkup)
  );

  stack_ptr_bank #(.W(W)) u_sp (
    .clk   (clk),
    .rst_n (rst_sync_n),
    .we    (sp_we),
    .wd    (sp_wd),
    .q     (sp_q)
  );

  save_pc_reg #(.W(W)) u_spc (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .entry    (exc_entry),
    .entry_pc (exc_pc),
    .wr       (cr_we_eff && (cr_addr == CRN_SAVEPC)),
    .wr_data  (cr_wdata),
    .save_q   (save_pc),
    .ret_addr (ret_pc)
  );

  always_comb begin
    status_img          = '0;
    status_img[BIT_C]   = live.c;
    status_img[BIT_IE]  = live.ie;
    status_img[BIT_SM]  = live.sm;
    status_img[BIT_BC]  = bkup.c;
    status_img[BIT_BIE] = bkup.ie;
    status_img[BIT_BSM] = bkup.sm;
  end

  always_comb begin
    cr_rdata = '0;
    unique case (cr_addr)
      CRN_STATUS: cr_rdata = status_img;
      CRN_CONDV:  cr_rdata[0] = live.c;
      CRN_ISTACK: cr_rdata = sp_q[SP_INT];
      CRN_USTACK: cr_rdata = sp_q[SP_USR];
      CRN_SAVEPC: cr_rdata = save_pc;
      default:    cr_rdata = '0;
    endcase
  end

  assign gpr15_rdata = live.sm ? sp_q[SP_USR] : sp_q[SP_INT];
  assign stack_sel   = live.sm;
  assign int_en      = live.ie;
  assign cond_flag   = live.c;
endmodule

// File: rtl/status_exc_checker.sv
module status_exc_checker
  import exc_regs_pkg::*;
#(
  parameter int unsigned W = 32
) (
  input logic             clk,
  input logic             rst_n,
  input logic             cr_wr_en,
  input logic [CR_AW-1:0] cr_addr,
  input logic [W-1:0]     cr_rdata,
  input logic             gpr15_wr_en,
  input logic [W-1:0]     gpr15_wdata,
  input logic             exc_entry,
  input logic [W-1:0]     exc_pc,
  input logic             exc_return,
  input mode_bits_t       live,
  input mode_bits_t       bkup,
  input logic [W-1:0]     save_pc,
  input logic [W-1:0]     isp,
  input logic [W-1:0]     usp
);
  p_cond_view_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (cr_addr == CRN_CONDV) |-> (cr_rdata == {{(W-1){1'b0}}, live.c}));

  p_isp_alias_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (gpr15_wr_en && !cr_wr_en && !exc_entry && !live.sm) |=> (isp == $past(gpr15_wdata)));

  p_usp_alias_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (gpr15_wr_en && !cr_wr_en && !exc_entry && live.sm) |=> (usp == $past(gpr15_wdata)));

  p_entry_backup_r5: assert property (@(posedge clk) disable iff (!rst_n)
    exc_entry |=> (bkup == $past(live)));

  p_entry_live_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    exc_entry |=> $stable(live));

  p_save_lsb_r6: assert property (@(posedge clk) disable iff (!rst_n)
    save_pc[0] == 1'b0);

  p_return_restore_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (exc_return && !exc_entry) |=> (live == $past(bkup)));

  p_entry_wins_r8: assert property (@(posedge clk) disable iff (!rst_n)
    exc_entry |=> (save_pc == {$past(exc_pc[W-1:1]), 1'b0}));
endmodule

bind status_exc_regfile status_exc_checker #(.W(W)) u_chk (
  .clk         (clk),
  .rst_n       (rst_sync_n),
  .cr_wr_en    (cr_wr_en),
  .cr_addr     (cr_addr),
  .cr_rdata    (cr_rdata),
  .gpr15_wr_en (gpr15_wr_en),
  .gpr15_wdata (gpr15_wdata),
  .exc_entry   (exc_entry),
  .exc_pc      (exc_pc),
  .exc_return  (exc_return),
  .live        (live),
  .bkup        (bkup),
  .save_pc     (save_pc),
  .isp         (sp_q[0]),
  .usp         (sp_q[1])
);

// File: tb/tb_status_exc_regfile.sv
module tb_status_exc_regfile;
  localparam int CLK_PERIOD = 10;
  localparam int W = 32;

  logic         clk = 1'b0;
  logic         rst_n;
  logic         cr_wr_en, gpr15_wr_en, cflag_wr_en, cflag_wdata;
  logic [2:0]   cr_addr;
  logic [W-1:0] cr_wdata, gpr15_wdata, exc_pc;
  logic         exc_entry, exc_return;
  logic [W-1:0] cr_rdata, gpr15_rdata, ret_pc;
  logic         stack_sel, int_en, cond_flag;

  int n_checks = 0;
  int n_fails  = 0;
  bit done     = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  status_exc_regfile #(.W(W)) dut (
    .clk(clk), .rst_n(rst_n),
    .cr_wr_en(cr_wr_en), .cr_addr(cr_addr), .cr_wdata(cr_wdata), .cr_rdata(cr_rdata),
    .gpr15_wr_en(gpr15_wr_en), .gpr15_wdata(gpr15_wdata), .gpr15_rdata(gpr15_rdata),
    .cflag_wr_en(cflag_wr_en), .cflag_wdata(cflag_wdata),
    .exc_entry(exc_entry), .exc_pc(exc_pc), .exc_return(exc_return),
    .ret_pc(ret_pc), .stack_sel(stack_sel), .int_en(int_en), .cond_flag(cond_flag)
  );

  // ops: 0 control write, 1 control read check, 2 reg15 write, 3 reg15 read check
  localparam int NV = 19;
  localparam int          V_OP  [NV] = '{0, 1, 1, 0, 1, 0, 3, 2, 1, 0, 3, 2, 1, 0, 1, 0, 1, 1, 1};
  localparam logic [2:0]  V_ADR [NV] = '{0, 0, 1, 1, 1, 3, 0, 0, 3, 0, 0, 0, 2, 6, 6, 5, 5, 4, 7};
  localparam logic [31:0] V_DAT [NV] = '{
    32'hFFFF_FFFF, 32'h0000_C1C1,   // R2
    32'h0000_0001,                  // R3
    32'h0000_0000, 32'h0000_0001,   // R3 write ignored
    32'h1111_2222, 32'h1111_2222,   // R4 user side
    32'hAAAA_0004, 32'hAAAA_0004,   // R4
    32'h0000_0000, 32'h0000_0000,   // R4 interrupt side
    32'h5555_0008, 32'h5555_0008,   // R4
    32'h1234_5677, 32'h1234_5676,   // R6
    32'h0000_DEAD, 32'h0000_0000,   // R10
    32'h0000_0000, 32'h0000_0000};  // R10
  localparam int V_REQ [NV] = '{2, 2, 3, 3, 3, 4, 4, 4, 4, 4, 4, 4, 4, 6, 6, 10, 10, 10, 10};

  task automatic check(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic idle();
    cr_wr_en = 0; gpr15_wr_en = 0; cflag_wr_en = 0; exc_entry = 0; exc_return = 0;
  endtask

  task automatic cr_write(input logic [2:0] a, input logic [W-1:0] d);
    @(negedge clk);
    cr_addr = a; cr_wdata = d; cr_wr_en = 1;
    @(negedge clk);
    idle();
  endtask

  task automatic cr_read(input string req, input logic [2:0] a, input logic [W-1:0] exp);
    @(negedge clk);
    cr_addr = a;
    #1 check(req, cr_rdata, exp);
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_fails++;
      n_checks++;
      $display("FAIL watchdog actual=hung expected=finished");
      summary();
    end
  end

  initial begin
    idle();
    cr_addr = 0; cr_wdata = 0; gpr15_wdata = 0; cflag_wdata = 0; exc_pc = 0;
    rst_n = 0;
    repeat (3) @(negedge clk);
    // R1 reset values
    cr_read("R1", 3'd0, 32'h0);
    cr_read("R1", 3'd2, 32'h0);
    cr_read("R1", 3'd6, 32'h0);
    check("R1", ret_pc, 32'h0);
    rst_n = 1;
    repeat (4) @(negedge clk);

    for (int i = 0; i < NV; i++) begin
      string rq;
      rq = $sformatf("R%0d", V_REQ[i]);
      case (V_OP[i])
        0: cr_write(V_ADR[i], V_DAT[i]);
        1: cr_read(rq, V_ADR[i], V_DAT[i]);
        2: begin
          @(negedge clk);
          gpr15_wdata = V_DAT[i]; gpr15_wr_en = 1;
          @(negedge clk);
          idle();
        end
        default: begin
          @(negedge clk);
          #1 check(rq, gpr15_rdata, V_DAT[i]);
        end
      endcase
    end

    // R9 flag update port
    @(negedge clk);
    cflag_wdata = 1; cflag_wr_en = 1;
    @(negedge clk);
    idle();
    cr_read("R9", 3'd1, 32'h1);
    cr_read("R9", 3'd0, 32'h1);
    // R9 status write beats flag update
    @(negedge clk);
    cr_addr = 3'd0; cr_wdata = 32'h0; cr_wr_en = 1; cflag_wdata = 1; cflag_wr_en = 1;
    @(negedge clk);
    idle();
    cr_read("R9", 3'd0, 32'h0);

    // R5, R6, R7 exception entry
    cr_write(3'd0, 32'h0000_00C1);
    @(negedge clk);
    exc_pc = 32'h0000_1003; exc_entry = 1;
    @(negedge clk);
    idle();
    cr_read("R5", 3'd0, 32'h0000_C1C1);
    cr_read("R6", 3'd6, 32'h0000_1002);
    check("R7", ret_pc, 32'h0000_1000);

    // R7 return restores saved fields
    cr_write(3'd0, 32'h0000_C100);
    cr_read("R7", 3'd0, 32'h0000_C100);
    @(negedge clk);
    exc_return = 1;
    @(negedge clk);
    idle();
    cr_read("R7", 3'd0, 32'h0000_C1C1);

    // R8 entry discards coincident control write
    cr_write(3'd0, 32'h0);
    @(negedge clk);
    exc_pc = 32'h0000_0020; exc_entry = 1;
    cr_addr = 3'd0; cr_wdata = 32'hFFFF_FFFF; cr_wr_en = 1;
    @(negedge clk);
    idle();
    cr_read("R8", 3'd0, 32'h0);
    cr_read("R8", 3'd6, 32'h0000_0020);

    // R1 reset mid-run
    @(negedge clk);
    rst_n = 0;
    #1;
    cr_read("R1", 3'd3, 32'h0);
    cr_read("R1", 3'd6, 32'h0);
    rst_n = 1;
    repeat (3) @(negedge clk);

    done = 1'b1;
    summary();
  end
endmodule